// File: doc/BRIEF.md
# Byte Mask, Insert and Zap Unit

This unit performs the byte-granular operations that a 64-bit integer pipeline needs for unaligned loads and stores and for byte-wise clearing. It can clear selected bytes of a value (zap and its complement), clear a sized field at a byte offset (mask low and mask high), move a value into a sized field at a byte offset and clear the rest (insert low and insert high), and compare two operands byte by byte to produce an 8-bit greater-or-equal mask.

The first operand is the value to operate on. The low bits of the second operand give a byte offset, or, for the zap forms, the low byte of the second operand is the byte-select mask. A kind code and a size code choose the operation. Every operation except the compare clears bytes of one source word. The clear mask comes from a size pattern shifted left by the offset. The low variants use the pattern bits that stay inside the word. The high variants use the bits that spill past byte 7. The result is captured in a register one clock after an accepted input.

Top module: `bmz_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_data` are cleared to zero.
- R2: Kind code 0 (zap): byte i of the result is zero when `in_sel[i]` is 1, and equals byte i of `in_val` otherwise.
- R3: Kind code 1 (zap-not): byte i of the result is zero when `in_sel[i]` is 0, and equals byte i of `in_val` otherwise.
- R4: Kind code 2 (mask low): with offset o = `in_sel[2:0]` and field length L = 1, 2, 4, 8 bytes for size codes 0, 1, 2, 3, the result is `in_val` with bytes o through min(o+L-1, 7) cleared.
- R5: Kind code 3 (mask high): the result is `in_val` with byte i cleared exactly when position i+8 lies in the window o to o+L-1. Offset and size are as in R4.
- R6: Kind code 4 (insert low): byte i of the result is byte i-o of `in_val` when i lies in o to o+L-1, and zero otherwise.
- R7: Kind code 5 (insert high): byte i of the result is byte i+8-o of `in_val` when i+8 lies in o to o+L-1, and zero otherwise. With offset 0 the result is all zeros.
- R8: Kind code 6 (byte compare): result bit i (i = 0 to 7) is 1 when byte i of `in_val` is greater than or equal to byte i of `in_sel` as an unsigned number. Bits 63:8 are zero.
- R9: `out_valid` is high in the cycle after a rising edge at which `in_valid` was high, and low after an edge at which it was low.
- R10: When `in_valid` is low at an edge, `out_data` keeps its previous value.
- R11: Kind code 7 is reserved and produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and codes are valid this cycle |
| in_kind | input | 3 | Operation kind code (0 to 7) |
| in_size | input | 2 | Field size code: 0 byte, 1 word, 2 longword, 3 quadword |
| in_val | input | 64 | Value operand |
| in_sel | input | 64 | Offset in bits 2:0, byte-select mask in bits 7:0, or compare operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Registered result |

## Verification
The bench targets windows that run past byte 7. A quadword or longword at a high offset must clip in the low forms and spill into the high forms; a design that took the wrong pattern half would clear or keep the wrong bytes. Insert-high at offset 0 is driven on purpose, because a full-width right shift that is handled naively would pass the value through instead of returning zero. The compare is checked with equal bytes and with bytes above 0x7F, which catches a strict compare or a signed compare. It is also checked in the top byte lane, which a seven-lane loop would miss. Idle cycles between operations check that the result register holds and that the valid flag drops.

// File: rtl/bmz_pkg.sv
package bmz_pkg;

    localparam int unsigned WORD_W  = 64;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned OFFS_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        K_ZAP    = 3'd0,
        K_ZAPNOT = 3'd1,
        K_MSKLO  = 3'd2,
        K_MSKHI  = 3'd3,
        K_INSLO  = 3'd4,
        K_INSHI  = 3'd5,
        K_CMPGE  = 3'd6,
        K_RSVD   = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } size_e;

    // Per-lane control chosen for one operation
    typedef struct packed {
        logic                use_cmp;
        logic                force_zero;
        logic [1:0]          src_pick;   // 0 raw, 1 shifted up, 2 shifted down
        logic [LANES-1:0]    clear;
    } lane_ctl_t;

    // Field pattern: L low lanes set, L = 1,2,4,8
    function automatic logic [LANES-1:0] field_pattern(input size_e sz);
        logic [LANES-1:0] p;
        p = '0;
        for (int i = 0; i < LANES; i++) begin
            p[i] = (i < (1 << sz));
        end
        return p;
    endfunction

endpackage

// File: rtl/bmz_window.sv
module bmz_window
    import bmz_pkg::*;
#(
    parameter int unsigned NLANES = LANES,
    parameter int unsigned OFFW   = OFFS_W
) (
    input  size_e              size,
    input  logic [OFFW-1:0]    offset,
    output logic [NLANES-1:0]  lo_lanes,
    output logic [NLANES-1:0]  hi_lanes
);
    localparam int unsigned PW = 2 * NLANES;

    logic [PW-1:0] spread;

    always_comb begin
        spread   = {{NLANES{1'b0}}, field_pattern(size)} << offset;
        lo_lanes = spread[NLANES-1:0];
        hi_lanes = spread[PW-1:NLANES];
    end
endmodule

// File: rtl/bmz_byte_clear.sv
module bmz_byte_clear #(
    parameter int unsigned NLANES = 8
) (
    input  logic [NLANES*8-1:0] src,
    input  logic [NLANES-1:0]   clear,
    output logic [NLANES*8-1:0] dst
);
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign dst[g*8 +: 8] = clear[g] ? 8'h00 : src[g*8 +: 8];
    end
endmodule

// File: rtl/bmz_lane_cmp.sv
module bmz_lane_cmp #(
    parameter int unsigned NLANES = 8
) (
    input  logic [NLANES*8-1:0] a,
    input  logic [NLANES*8-1:0] b,
    output logic [NLANES-1:0]   ge
);
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign ge[g] = (a[g*8 +: 8] >= b[g*8 +: 8]);
    end
endmodule

// File: rtl/bmz_unit.sv
module bmz_unit
    import bmz_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_kind,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_val,
    input  logic [DATA_W-1:0] in_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned NL   = DATA_W / 8;
    localparam int unsigned OW   = $clog2(NL);
    localparam int unsigned SH_W = $clog2(DATA_W) + 1;

    kind_e             kind;
    size_e             size;
    logic [OW-1:0]     offset;
    logic [SH_W-1:0]   up_amt;
    logic [NL-1:0]     lo_lanes, hi_lanes;
    logic [DATA_W-1:0] up_val, down_val, src_val, cleared;
    logic [NL-1:0]     ge_bits;
    lane_ctl_t         ctl;
    logic [DATA_W-1:0] next_data;

    assign kind   = kind_e'(in_kind);
    assign size   = size_e'(in_size);
    assign offset = in_sel[OW-1:0];
    assign up_amt = SH_W'(offset) << 3;

    bmz_window #(.NLANES(NL), .OFFW(OW)) win_i (
        .size     (size),
        .offset   (offset),
        .lo_lanes (lo_lanes),
        .hi_lanes (hi_lanes)
    );

    // Shifted sources for the insert forms; a zero offset down-shift is empty
    always_comb begin
        up_val = in_val << up_amt;
        if (offset == '0) begin
            down_val = '0;
        end else begin
            down_val = in_val >> (SH_W'(DATA_W) - up_amt);
        end
    end

    always_comb begin
        ctl = '{use_cmp: 1'b0, force_zero: 1'b0, src_pick: 2'd0, clear: '0};
        unique case (kind)
            K_ZAP:    ctl.clear = in_sel[NL-1:0];
            K_ZAPNOT: ctl.clear = ~in_sel[NL-1:0];
            K_MSKLO:  ctl.clear = lo_lanes;
            K_MSKHI:  ctl.clear = hi_lanes;
            K_INSLO: begin
                ctl.src_pick = 2'd1;
                ctl.clear    = ~lo_lanes;
            end
            K_INSHI: begin
                ctl.src_pick = 2'd2;
                ctl.clear    = ~hi_lanes;
            end
            K_CMPGE:  ctl.use_cmp    = 1'b1;
            default:  ctl.force_zero = 1'b1;
        endcase
    end

    always_comb begin
        unique case (ctl.src_pick)
            2'd1:    src_val = up_val;
            2'd2:    src_val = down_val;
            default: src_val = in_val;
        endcase
    end

    bmz_byte_clear #(.NLANES(NL)) clr_i (
        .src   (src_val),
        .clear (ctl.clear),
        .dst   (cleared)
    );

    bmz_lane_cmp #(.NLANES(NL)) cmp_i (
        .a  (in_val),
        .b  (in_sel),
        .ge (ge_bits)
    );

    always_comb begin
        if (ctl.force_zero) begin
            next_data = '0;
        end else if (ctl.use_cmp) begin
            next_data = {{(DATA_W-NL){1'b0}}, ge_bits};
        end else begin
            next_data = cleared;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_data;
            end
        end
    end
endmodule

// File: rtl/bmz_unit_chk.sv
module bmz_unit_chk #(
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        in_kind,
    input logic [1:0]        in_size,
    input logic [DATA_W-1:0] in_val,
    input logic [DATA_W-1:0] in_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int unsigned NL = DATA_W / 8;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    a_r8_cmp_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 3'd6) |=> (out_data[DATA_W-1:NL] == '0));

    a_r7_inshi_off0_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 3'd5 && in_sel[2:0] == 3'd0) |=> (out_data == '0));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 3'd7) |=> (out_data == '0));

    a_r2_zap_all: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 3'd0 && in_sel[NL-1:0] == '1) |=> (out_data == '0));

    a_r3_zapnot_keep: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 3'd1 && in_sel[NL-1:0] == '1) |=> (out_data == $past(in_val)));
endmodule

bind bmz_unit bmz_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/bmz_unit_tb_top.sv
module bmz_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_kind = '0;
    logic [1:0]  in_size = '0;
    logic [63:0] in_val = '0;
    logic [63:0] in_sel = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    exp_valid = 1'b0;
    logic [63:0] exp_data = '0;
    string exp_tag = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    bmz_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_size(in_size), .in_val(in_val), .in_sel(in_sel),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] lane(input logic [63:0] w, input int i);
        return w[i*8 +: 8];
    endfunction

    // Behavioural model built from the requirement text
    function automatic logic [63:0] model(input int k, input int sz,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        int o = int'(b[2:0]);
        int len = 1 << sz;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v = 8'h00;
            case (k)
                0: v = b[i] ? 8'h00 : lane(a, i);
                1: v = b[i] ? lane(a, i) : 8'h00;
                2: v = (i >= o && i < o + len) ? 8'h00 : lane(a, i);
                3: v = (i + 8 >= o && i + 8 < o + len) ? 8'h00 : lane(a, i);
                4: v = (i >= o && i < o + len) ? lane(a, i - o) : 8'h00;
                5: v = (i + 8 >= o && i + 8 < o + len) ? lane(a, i + 8 - o) : 8'h00;
                default: v = 8'h00;
            endcase
            r[i*8 +: 8] = v;
        end
        if (k == 6) begin
            r = '0;
            for (int i = 0; i < 8; i++) r[i] = (lane(a, i) >= lane(b, i));
        end
        return r;
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic compare_now();
        n_cmp++;
        if (out_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL %s/R9 out_valid actual=%0b expected=%0b", exp_tag, out_valid, exp_valid);
        end
        n_cmp++;
        if (out_data !== exp_data) begin
            n_bad++;
            $display("FAIL %s out_data actual=%h expected=%h", exp_tag, out_data, exp_data);
        end
    endtask

    // One cycle: check outputs, drive new inputs, advance model
    task automatic cycle(input bit v, input int k, input int sz,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        compare_now();
        in_valid = v;
        in_kind  = 3'(k);
        in_size  = 2'(sz);
        in_val   = a;
        in_sel   = b;
        exp_valid = v;
        if (v) begin
            exp_data = model(k, sz, a, b);
            exp_tag  = tag_of(k);
        end else begin
            exp_tag = "R10";
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] pat = 64'h8877_6655_4433_2211;
        repeat (3) @(posedge clk);
        in_valid = 1'b1;            // inputs active during reset must not leak
        in_kind  = 3'd4;
        in_val   = pat;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        exp_valid = 1'b0;
        exp_data  = '0;
        exp_tag   = "R1";
        // R1: reset state observed in first cycle
        cycle(1, 0, 0, pat, 64'h0000_0000_0000_00A5);      // R2 zap
        cycle(1, 0, 0, pat, 64'hFFFF_FFFF_FFFF_FFFF);      // R2 zap all lanes
        cycle(1, 1, 0, pat, 64'h0000_0000_0000_000F);      // R3 zap-not
        cycle(1, 1, 0, pat, 64'h0000_0000_0000_0000);      // R3 clear all
        cycle(0, 6, 0, '1, '0);                             // R10 idle hold
        cycle(0, 0, 0, '0, '0);                             // R10 idle again
        for (int sz = 0; sz < 4; sz++) begin
            for (int o = 0; o < 8; o++) begin
                cycle(1, 2, sz, pat, 64'(o));               // R4
                cycle(1, 3, sz, pat, 64'(o));               // R5
                cycle(1, 4, sz, pat, 64'(o) | 64'hF0);      // R6
                cycle(1, 5, sz, pat, 64'(o));               // R7, o=0 gives zero
            end
        end
        cycle(1, 6, 0, 64'h80FF_0010_7F00_0001, 64'h7FFF_0011_8000_0101);  // R8 signed/equal
        cycle(1, 6, 0, 64'hFF00_0000_0000_0000, 64'h0000_0000_0000_00FF);  // R8 top lane
        cycle(1, 7, 3, pat, 64'h3);                                         // R11
        cycle(0, 7, 3, '0, '0);
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            cycle(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 4), a, b);
        end
        cycle(0, 0, 0, '0, '0);
        @(negedge clk);
        compare_now();
        // R1: reset again after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_valid = 1'b0;
        exp_data  = '0;
        exp_tag   = "R1";
        compare_now();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule